// File: doc/BRIEF.md
# Vectored interrupt controller

This block gathers 32 interrupt request lines and drives the two interrupt inputs of a processor: a fast interrupt and a normal interrupt. Software sorts each source into one of two classes, fast or vectored, and enables it. Each vectored source gets a 4-bit urgency level and a handler address. Every enabled, active fast-class request feeds the fast output. Among the vectored requests, the block picks one winner and serves its handler address from a readable register.

Reading the vector register starts service of the winner. The winner's level is latched, and every source that is not strictly more urgent is held back until software writes the same register to acknowledge. This gives one level of priority masking. A small word-addressed register bus carries all programming. Level 0 is the most urgent. When no vectored source is eligible, the vector register returns a programmable default address.

Top module: `vic_top`

## Requirements
- R1: After reset both interrupt outputs are low, the enable and class masks are zero, every urgency level is 4'hF, and every handler address and the default address are zero.
- R2: `fiqOut` is high exactly when at least one request has its enable bit set and its class bit set (class bit 1 = fast).
- R3: Reads return the raw request lines at word 0x00, the enabled fast-class requests at word 0x03, and the enabled vectored-class requests at word 0x04. Bit n of each word is source n. These reads have no side effect.
- R4: `irqOut` is high exactly when at least one enabled vectored-class request is active and not held back by the service mask.
- R5: The winner is the eligible vectored source with the numerically smallest level. Among equal levels, the lowest source number wins.
- R6: A read of word 0x05 returns the winner's handler address, or the default address (word 0x06) when no vectored source is eligible.
- R7: A read of word 0x05 that finds a winner latches the winner's level. While latched, sources whose level is greater than or equal to the latched level are excluded from `irqOut` and from selection. A read that finds no winner leaves the mask unchanged.
- R8: Any write to word 0x05 releases the service mask, whatever data it carries.
- R9: A source with a clear enable bit reaches neither output nor a status word. A fast-class source never takes part in vectored selection.
- R10: The enable mask (word 0x01), class mask (word 0x02), default address (word 0x06), level of source n (word 0x20+n, bits 3:0) and handler address of source n (word 0x40+n) can be written and read back. Unmapped words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqReq | input | 32 | Interrupt request lines, active high, one per source |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 7 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as a read, zero otherwise |
| fiqOut | output | 1 | Fast interrupt to the processor |
| irqOut | output | 1 | Normal interrupt to the processor |

## Verification
Two functions can fall on the same clock edge. In the first, the request pattern or an urgency level changes in the cycle where the vector register is read. The mask must then latch the level of the winner seen in that read cycle, not the one after it. In the second, an acknowledge write lands while a more urgent source is already asserting. The bench provokes both with directed sequences and with a random phase that mixes request changes, vector reads, acknowledges and level writes. A behavioural reference model, compared at every falling edge, judges both outputs and every read value.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  localparam logic [1:0] GRP_CTRL = 2'b00;
  localparam logic [1:0] GRP_PRIO = 2'b01;
  localparam logic [1:0] GRP_VEC  = 2'b10;

  localparam logic [4:0] OFS_RAW     = 5'h00;
  localparam logic [4:0] OFS_ENABLE  = 5'h01;
  localparam logic [4:0] OFS_CLASS   = 5'h02;
  localparam logic [4:0] OFS_FASTST  = 5'h03;
  localparam logic [4:0] OFS_VECST   = 5'h04;
  localparam logic [4:0] OFS_VECTOR  = 5'h05;
  localparam logic [4:0] OFS_DEFAULT = 5'h06;

  // strobes from control to datapath
  typedef struct packed {
    logic rdEn;
    logic wrEnable;
    logic wrClass;
    logic wrDefault;
    logic wrPrio;
    logic wrVecAddr;
    logic vecRead;
    logic ackWrite;
  } dpStrobe_t;
endpackage

// File: rtl/vic_arb.sv
`timescale 1ns/1ps
module vic_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  localparam int SRC_IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             eligible,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           winValid,
  output logic [SRC_IDX_W-1:0]           winIdx,
  output logic [PRIO_W-1:0]              winPrio
);
  // scan from the top index down; "<=" lets a lower index take a tie
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPrio  = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && (!winValid || prio[i] <= winPrio)) begin
        winValid = 1'b1;
        winPrio  = prio[i];
        winIdx   = SRC_IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_ctrl.sv
`timescale 1ns/1ps
module vic_ctrl #(
  parameter int ADDR_W = 7,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              winValid,
  input  logic [PRIO_W-1:0] winPrio,
  output vic_pkg::dpStrobe_t strobe,
  output logic              maskActive,
  output logic [PRIO_W-1:0] maskLevel
);
  import vic_pkg::*;

  localparam int OFS_W = ADDR_W - 2;

  logic [1:0]       grp;
  logic [OFS_W-1:0] ofs;
  logic             isWrite;
  logic             isRead;

  assign grp     = busAddr[ADDR_W-1 -: 2];
  assign ofs     = busAddr[OFS_W-1:0];
  assign isWrite = busSel && busWrite;
  assign isRead  = busSel && !busWrite;

  always_comb begin
    strobe           = '0;
    strobe.rdEn      = isRead;
    strobe.wrPrio    = isWrite && (grp == GRP_PRIO);
    strobe.wrVecAddr = isWrite && (grp == GRP_VEC);
    if (grp == GRP_CTRL) begin
      strobe.wrEnable  = isWrite && (ofs == OFS_ENABLE);
      strobe.wrClass   = isWrite && (ofs == OFS_CLASS);
      strobe.wrDefault = isWrite && (ofs == OFS_DEFAULT);
      strobe.ackWrite  = isWrite && (ofs == OFS_VECTOR);
      strobe.vecRead   = isRead  && (ofs == OFS_VECTOR);
    end
  end

  // one level of service masking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskActive <= 1'b0;
      maskLevel  <= '1;
    end else if (strobe.ackWrite) begin
      maskActive <= 1'b0;
    end else if (strobe.vecRead && winValid) begin
      maskActive <= 1'b1;
      maskLevel  <= winPrio;
    end
  end
endmodule

// File: rtl/vic_dp.sv
`timescale 1ns/1ps
module vic_dp #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 7,
  localparam int SRC_IDX_W = $clog2(NUM_SRC),
  localparam int OFS_W     = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  vic_pkg::dpStrobe_t strobe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               maskActive,
  input  logic [PRIO_W-1:0]  maskLevel,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_SRC-1:0] enableMask,
  output logic [NUM_SRC-1:0] classMask,
  output logic               winValid,
  output logic [PRIO_W-1:0]  winPrio,
  output logic               fiqOut,
  output logic               irqOut
);
  import vic_pkg::*;

  logic [NUM_SRC-1:0][PRIO_W-1:0] prioReg;
  logic [NUM_SRC-1:0][DATA_W-1:0] vecAddr;
  logic [DATA_W-1:0]              defaultAddr;
  logic [NUM_SRC-1:0]             fastPend;
  logic [NUM_SRC-1:0]             vecPend;
  logic [NUM_SRC-1:0]             masked;
  logic [NUM_SRC-1:0]             eligible;
  logic [SRC_IDX_W-1:0]           winIdx;
  logic [SRC_IDX_W-1:0]           idx;
  logic [1:0]                     grp;
  logic [OFS_W-1:0]               ofs;
  logic [DATA_W-1:0]              vectorValue;

  assign idx = busAddr[SRC_IDX_W-1:0];
  assign grp = busAddr[ADDR_W-1 -: 2];
  assign ofs = busAddr[OFS_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableMask  <= '0;
      classMask   <= '0;
      defaultAddr <= '0;
    end else begin
      if (strobe.wrEnable)  enableMask  <= busWdata[NUM_SRC-1:0];
      if (strobe.wrClass)   classMask   <= busWdata[NUM_SRC-1:0];
      if (strobe.wrDefault) defaultAddr <= busWdata;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioReg[g] <= '1;
        vecAddr[g] <= '0;
      end else begin
        if (strobe.wrPrio && idx == SRC_IDX_W'(g))    prioReg[g] <= busWdata[PRIO_W-1:0];
        if (strobe.wrVecAddr && idx == SRC_IDX_W'(g)) vecAddr[g] <= busWdata;
      end
    end
    assign masked[g] = maskActive && (prioReg[g] >= maskLevel);
  end

  assign fastPend = irqReq & enableMask & classMask;
  assign vecPend  = irqReq & enableMask & ~classMask;
  assign eligible = vecPend & ~masked;

  vic_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_arb (
    .eligible (eligible),
    .prio     (prioReg),
    .winValid (winValid),
    .winIdx   (winIdx),
    .winPrio  (winPrio)
  );

  assign fiqOut      = |fastPend;
  assign irqOut      = winValid;
  assign vectorValue = winValid ? vecAddr[winIdx] : defaultAddr;

  always_comb begin
    busRdata = '0;
    if (strobe.rdEn) begin
      case (grp)
        GRP_CTRL: begin
          case (ofs)
            OFS_RAW:     busRdata = DATA_W'(irqReq);
            OFS_ENABLE:  busRdata = DATA_W'(enableMask);
            OFS_CLASS:   busRdata = DATA_W'(classMask);
            OFS_FASTST:  busRdata = DATA_W'(fastPend);
            OFS_VECST:   busRdata = DATA_W'(vecPend);
            OFS_VECTOR:  busRdata = vectorValue;
            OFS_DEFAULT: busRdata = defaultAddr;
            default:     busRdata = '0;
          endcase
        end
        GRP_PRIO: busRdata = DATA_W'(prioReg[idx]);
        GRP_VEC:  busRdata = vecAddr[idx];
        default:  busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vic_top.sv
`timescale 1ns/1ps
module vic_top #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               fiqOut,
  output logic               irqOut
);
  vic_pkg::dpStrobe_t strobe;
  logic               maskActive;
  logic [PRIO_W-1:0]  maskLevel;
  logic               winValid;
  logic [PRIO_W-1:0]  winPrio;
  logic [NUM_SRC-1:0] enableMask;
  logic [NUM_SRC-1:0] classMask;

  vic_ctrl #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .winValid   (winValid),
    .winPrio    (winPrio),
    .strobe     (strobe),
    .maskActive (maskActive),
    .maskLevel  (maskLevel)
  );

  vic_dp #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .irqReq     (irqReq),
    .strobe     (strobe),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .maskActive (maskActive),
    .maskLevel  (maskLevel),
    .busRdata   (busRdata),
    .enableMask (enableMask),
    .classMask  (classMask),
    .winValid   (winValid),
    .winPrio    (winPrio),
    .fiqOut     (fiqOut),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/vic_checker.sv
`timescale 1ns/1ps
module vic_checker #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqReq,
  input logic [NUM_SRC-1:0] enableMask,
  input logic [NUM_SRC-1:0] classMask,
  input logic               fiqOut,
  input logic               irqOut,
  input vic_pkg::dpStrobe_t strobe,
  input logic               maskActive,
  input logic [PRIO_W-1:0]  maskLevel,
  input logic               winValid,
  input logic [PRIO_W-1:0]  winPrio
);
  p_fiq_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> (|(irqReq & enableMask & classMask)));

  p_fiq_raise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|(irqReq & enableMask & classMask)) |-> fiqOut);

  p_irq_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|(irqReq & enableMask & ~classMask)));

  p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((irqReq & enableMask) == '0) |-> (!fiqOut && !irqOut));

  p_latch_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.vecRead && winValid) |=> (maskActive && maskLevel == $past(winPrio)));

  p_masked_winner_r7: assert property (@(posedge clk) disable iff (!rstN)
    (maskActive && winValid) |-> (winPrio < maskLevel));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (maskActive && !strobe.vecRead && !strobe.ackWrite) |=> (maskActive && $stable(maskLevel)));

  p_ack_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackWrite |=> !maskActive);
endmodule

bind vic_top vic_checker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_vicChecker (
  .clk        (clk),
  .rstN       (rstN),
  .irqReq     (irqReq),
  .enableMask (enableMask),
  .classMask  (classMask),
  .fiqOut     (fiqOut),
  .irqOut     (irqOut),
  .strobe     (strobe),
  .maskActive (maskActive),
  .maskLevel  (maskLevel),
  .winValid   (winValid),
  .winPrio    (winPrio)
);

// File: tb/test_vic_top.sv
`timescale 1ns/1ps
module test_vic_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqReq = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        fiqOut;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vic_top i_vic_top (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .fiqOut(fiqOut), .irqOut(irqOut)
  );

  // ---------------- reference model ----------------
  logic [31:0] enM, clM, defM;
  logic [31:0] vecM [32];
  int          prioM [32];
  bit          mActM;
  int          mLvlM;

  function automatic void pickWinner(output bit valid, output int win);
    int best;
    valid = 0; win = 0; best = 99;
    for (int i = 0; i < 32; i++) begin
      if (irqReq[i] && enM[i] && !clM[i] && (!mActM || prioM[i] < mLvlM) && prioM[i] < best) begin
        valid = 1; win = i; best = prioM[i];
      end
    end
  endfunction

  function automatic logic [31:0] expRead(logic [6:0] a);
    bit v; int w;
    pickWinner(v, w);
    case (a[6:5])
      2'b00: case (a[4:0])
        5'h00: return irqReq;
        5'h01: return enM;
        5'h02: return clM;
        5'h03: return irqReq & enM & clM;
        5'h04: return irqReq & enM & ~clM;
        5'h05: return v ? vecM[w] : defM;
        5'h06: return defM;
        default: return '0;
      endcase
      2'b01: return 32'(prioM[a[4:0]]);
      2'b10: return vecM[a[4:0]];
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enM = '0; clM = '0; defM = '0; mActM = 0; mLvlM = 15;
      for (int i = 0; i < 32; i++) begin vecM[i] = '0; prioM[i] = 15; end
    end else if (busSel) begin
      if (busWrite) begin
        case (busAddr[6:5])
          2'b00: case (busAddr[4:0])
            5'h01: enM = busWdata;
            5'h02: clM = busWdata;
            5'h05: mActM = 0;
            5'h06: defM = busWdata;
            default: ;
          endcase
          2'b01: prioM[busAddr[4:0]] = int'(busWdata[3:0]);
          2'b10: vecM[busAddr[4:0]] = busWdata;
          default: ;
        endcase
      end else if (busAddr == 7'h05) begin
        bit v; int w;
        pickWinner(v, w);
        if (v) begin mActM = 1; mLvlM = prioM[w]; end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model on every falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit v; int w;
      string tag;
      pickWinner(v, w);
      check("R2 fiqOut vs model", 32'(fiqOut), 32'(|(irqReq & enM & clM)));
      check("R4 irqOut vs model", 32'(irqOut), 32'(v));
      tag = (busAddr == 7'h05) ? "R6 read vs model" :
            (busAddr[6:5] == 2'b00 && busAddr[4:0] inside {5'h00, 5'h03, 5'h04}) ? "R3 read vs model" :
            "R10 read vs model";
      check(tag, busRdata, (busSel && !busWrite) ? expRead(busAddr) : 32'h0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic busWr(logic [6:0] a, logic [31:0] d);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    tick();
    busSel = 0; busWrite = 0; busAddr = '0; busWdata = '0;
  endtask

  task automatic busRd(logic [6:0] a, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = a;
    @(negedge clk); d = busRdata;
    tick();
    busSel = 0; busAddr = '0;
  endtask

  task automatic peek(output logic f, output logic i);
    @(negedge clk); f = fiqOut; i = irqOut;
    tick();
  endtask

  localparam logic [31:0] DEF = 32'hDEAD_0000;
  function automatic logic [31:0] hAddr(int n);
    return 32'h1000_0000 + 32'(n * 16);
  endfunction

  initial begin
    logic [31:0] d;
    logic f, i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 fiqOut in reset", 32'(fiqOut), 0);
    check("R1 irqOut in reset", 32'(irqOut), 0);
    @(posedge clk); #1 rstN = 1;
    busRd(7'h01, d); check("R1 enable reset", d, 0);
    busRd(7'h02, d); check("R1 class reset", d, 0);
    busRd(7'h25, d); check("R1 level reset", d, 32'hF);
    busRd(7'h47, d); check("R1 handler reset", d, 0);
    busRd(7'h05, d); check("R1 vector reset = default 0", d, 0);

    for (int n = 0; n < 32; n++) busWr(7'h40 + 7'(n), hAddr(n));
    busWr(7'h06, DEF);
    busWr(7'h01, 32'h0000_00FF);
    busWr(7'h02, 32'h0000_0042);
    busWr(7'h23, 32'h2);
    busWr(7'h25, 32'h2);
    busWr(7'h24, 32'h7);

    irqReq = 32'h2;
    peek(f, i);
    check("R2 fast source raises fiqOut", 32'(f), 1);
    check("R4 fast source leaves irqOut low", 32'(i), 0);
    busRd(7'h03, d); check("R3 fast status", d, 32'h2);

    irqReq = 32'h200;
    peek(f, i);
    check("R9 disabled source fiqOut", 32'(f), 0);
    check("R9 disabled source irqOut", 32'(i), 0);
    busRd(7'h00, d); check("R3 raw status", d, 32'h200);
    busRd(7'h04, d); check("R9 disabled absent from vectored status", d, 0);

    irqReq = 32'h38;
    peek(f, i); check("R4 vectored raises irqOut", 32'(i), 1);
    busRd(7'h05, d); check("R5 tie goes to lowest index", d, hAddr(3));
    peek(f, i); check("R7 equal and lower urgency masked", 32'(i), 0);
    busRd(7'h05, d); check("R7 masked read gives default", d, DEF);
    busRd(7'h04, d); check("R3 vectored status unaffected by mask", d, 32'h38);

    busWr(7'h24, 32'h1);
    peek(f, i); check("R7 more urgent source passes mask", 32'(i), 1);
    busRd(7'h05, d); check("R6 vector of more urgent source", d, hAddr(4));
    peek(f, i); check("R7 relatched at level 1", 32'(i), 0);

    busWr(7'h05, 32'h1234_5678);
    peek(f, i); check("R8 ack releases mask", 32'(i), 1);
    busRd(7'h05, d); check("R5 lowest level wins", d, hAddr(4));
    busWr(7'h05, 32'h0);

    busWr(7'h02, 32'h0000_004A);
    peek(f, i); check("R9 reclassified source raises fiqOut", 32'(f), 1);
    busWr(7'h24, 32'h7);
    busRd(7'h05, d); check("R9 fast source skipped in selection", d, hAddr(5));
    busWr(7'h05, 32'h0);

    busWr(7'h2A, 32'h0);
    irqReq = 32'h420;
    busRd(7'h05, d); check("R9 disabled urgent source ignored", d, hAddr(5));
    busWr(7'h05, 32'h0);

    irqReq = 32'h0;
    busRd(7'h05, d); check("R6 no pending gives default", d, DEF);
    peek(f, i); check("R4 irqOut low with nothing pending", 32'(i), 0);

    busRd(7'h25, d); check("R10 level readback", d, 32'h2);
    busRd(7'h47, d); check("R10 handler readback", d, hAddr(7));
    busRd(7'h06, d); check("R10 default readback", d, DEF);
    busRd(7'h1F, d); check("R10 unmapped reads zero", d, 0);

    // random phase, judged by the model on every clock
    busWr(7'h01, 32'hFFFF_0FFF);
    busWr(7'h02, 32'h0F00_0401);
    for (int k = 0; k < 600; k++) begin
      int op;
      irqReq = $urandom & $urandom;
      op = int'($urandom % 6);
      case (op)
        0: busRd(7'h05, d);
        1: busWr(7'h05, $urandom);
        2: busWr(7'h20 + 7'($urandom % 32), $urandom);
        3: busRd(7'h04, d);
        default: tick();
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule